// File: doc/BRIEF.md
# Energy Pulse Output Generator

This block turns a stream of signed active-power samples into energy pulses on two active-low outputs. A sample arrives with a one-cycle sample strobe. Each accepted sample is added to a signed energy accumulator. When the running energy reaches a programmable quantum in either direction, the block takes one quantum out of the accumulator and requests a pulse. The pulse rate is therefore proportional to power. Each pulse stays low for a programmable number of sample periods.

A small register write port holds the pulse width and a control word. The control word selects one of three output formats. In normal format, forward quanta go to output A and reverse quanta to output B. In mechanical-counter format, only output A counts forward energy. In stepper-motor format, forward quanta alternate between A and B. The control word also enables anti-creep gating. While anti-creep is enabled and the external no-load flag is high, samples are not accumulated and no pulse starts.

Each output can hold one pending request. A quantum that arrives while its output is still low is issued as soon as the output has gone back high.

Top module: `energy_pulse_gen`

## Requirements
- R1: After reset both outputs are high, the pulse width is 512 sample periods and the control word is zero, which selects normal format.
- R2: On each accepted strobe, the sample is added to the accumulator. If the sum is at least the quantum, one quantum is subtracted and a forward quantum occurs. If the sum is at or below minus the quantum, one quantum is added and a reverse quantum occurs. In normal format, forward quanta pulse output A and reverse quanta pulse output B.
- R3: A pulse goes low on the clock edge that ends the strobe cycle of its quantum. It returns high on the edge that ends the W-th later strobe, where W is the width register. A width of 0 acts as 1.
- R4: A write with address 0 loads the width register. A write with address 1 loads the control word, where bit 0 selects stepper format, bit 1 selects mechanical-counter format and bit 2 enables anti-creep.
- R5: A quantum that arrives while its output is low is held as one pending pulse. That pulse starts on the clock after the output returns high, so the output is high for one clock. Further quanta that arrive while a pulse is already pending are dropped.
- R6: In mechanical-counter format (control bit 1 set, bit 0 clear), forward quanta pulse output A only, and reverse quanta produce no pulse.
- R7: In stepper format (control bit 0 set), forward quanta pulse A and B alternately, starting with A after reset. Reverse quanta produce no pulse. Bit 0 takes precedence over bit 1.
- R8: While control bit 2 and no_load are both high, strobes leave the accumulator unchanged and no pulse starts. A pulse that is already low finishes normally.
- R9: With control bit 2 clear, no_load has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_stb | input | 1 | One-cycle strobe per sample period |
| power_in | input | 16 | Signed active-power sample |
| quantum | input | 16 | Unsigned energy per pulse |
| no_load | input | 1 | No-load indication used by anti-creep |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 1 | 0 = width register, 1 = control word |
| wr_data | input | 24 | Write data |
| pulse_a_n | output | 1 | Active-low energy output A |
| pulse_b_n | output | 1 | Active-low energy output B |

## Verification
The bench goes after the threshold edges. A sum exactly equal to the quantum must fire, and a sum one short must not. A design that used a strict compare would lose pulses, and one that did not subtract the quantum would fire on every following sample. The bench measures pulse length in clocks, including the 512 default and a width of zero. An off-by-one in the strobe counter shows up as a pulse four clocks too long or too short. The bench also overloads a busy output. A design without the pending slot loses the second pulse, and one with a deeper queue emits a third. Finally, the bench drives format and anti-creep combinations. These catch wrong stepper alternation, lost stepper precedence, reverse pulses in the counter formats, and energy that accumulates during no-load and later leaks out as a pulse.

// File: rtl/epg_pkg.sv
package epg_pkg;
  localparam int DATA_W = 16;
  localparam int ACC_W  = DATA_W + 2;
  localparam int CTRL_W = 3;

  typedef enum logic [1:0] {
    FMT_NORMAL = 2'd0,
    FMT_MECH   = 2'd1,
    FMT_STEP   = 2'd2
  } fmt_e;

  typedef struct packed {
    logic signed [ACC_W-1:0] nxt;
    logic                    fwd;
    logic                    rev;
  } step_t;

  // Stepper selection outranks the counter selection.
  function automatic fmt_e decode_fmt(input logic [CTRL_W-1:0] c);
    if (c[0])      return FMT_STEP;
    else if (c[1]) return FMT_MECH;
    else           return FMT_NORMAL;
  endfunction

  // One accumulation step: add the sample, take out at most one quantum.
  function automatic step_t acc_step(input logic signed [ACC_W-1:0] acc,
                                     input logic signed [DATA_W-1:0] s,
                                     input logic [DATA_W-1:0] q);
    step_t r;
    logic signed [ACC_W-1:0] sum;
    logic signed [ACC_W-1:0] qs;
    qs  = $signed({{(ACC_W-DATA_W){1'b0}}, q});
    sum = acc + $signed({{(ACC_W-DATA_W){s[DATA_W-1]}}, s});
    r.fwd = 1'b0;
    r.rev = 1'b0;
    r.nxt = sum;
    if (qs > 0) begin
      if (sum >= qs) begin
        r.fwd = 1'b1;
        r.nxt = sum - qs;
      end else if (sum <= -qs) begin
        r.rev = 1'b1;
        r.nxt = sum + qs;
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/epg_accum.sv
module epg_accum
  import epg_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     stb,
  input  logic                     block,
  input  logic signed [DATA_W-1:0] sample,
  input  logic [DATA_W-1:0]        quantum,
  output logic                     ev_fwd,
  output logic                     ev_rev
);
  logic signed [ACC_W-1:0] acc_q;
  step_t                   st;
  logic                    take;

  assign take   = stb && !block;
  assign st     = acc_step(acc_q, sample, quantum);
  assign ev_fwd = take && st.fwd;
  assign ev_rev = take && st.rev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    acc_q <= '0;
    else if (take) acc_q <= st.nxt;
  end

  // R2: a strobe yields at most one quantum direction
  assert_one_dir_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_fwd && ev_rev));

  // R8: a gated strobe leaves the stored energy alone
  assert_creep_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && block) |=> $stable(acc_q));
endmodule

// File: rtl/epg_route.sv
module epg_route
  import epg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  fmt_e fmt,
  input  logic ev_fwd,
  input  logic ev_rev,
  output logic req_a,
  output logic req_b
);
  logic tog_q;

  always_comb begin
    req_a = 1'b0;
    req_b = 1'b0;
    unique case (fmt)
      FMT_NORMAL: begin
        req_a = ev_fwd;
        req_b = ev_rev;
      end
      FMT_MECH: req_a = ev_fwd;
      FMT_STEP: begin
        req_a = ev_fwd && !tog_q;
        req_b = ev_fwd && tog_q;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           tog_q <= 1'b0;
    else if (fmt == FMT_STEP && ev_fwd)   tog_q <= ~tog_q;
  end

  // R7: each stepper pulse hands the next one to the other output
  assert_step_alt_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt == FMT_STEP && ev_fwd) |=> (tog_q != $past(tog_q)));

  // R6: counter format never drives output B
  assert_mech_b_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt == FMT_MECH) |-> !req_b);
endmodule

// File: rtl/epg_channel.sv
module epg_channel #(
  parameter int WIDTH_W = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               stb,
  input  logic               block,
  input  logic               req,
  input  logic [WIDTH_W-1:0] width,
  output logic               pulse_n
);
  logic               active_q;
  logic               pend_q;
  logic [WIDTH_W-1:0] cnt_q;
  logic [WIDTH_W:0]   eff_width;
  logic               start_evt;
  logic               end_evt;

  assign eff_width = (width == '0) ? {{WIDTH_W{1'b0}}, 1'b1} : {1'b0, width};
  assign start_evt = !active_q && !block && (pend_q || req);
  assign end_evt   = active_q && stb && (({1'b0, cnt_q} + 1'b1) >= eff_width);
  assign pulse_n   = !active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      pend_q   <= 1'b0;
      cnt_q    <= '0;
    end else if (start_evt) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
      pend_q   <= pend_q && req;
    end else begin
      if (req) pend_q <= 1'b1;
      if (end_evt)                active_q <= 1'b0;
      else if (active_q && stb)   cnt_q    <= cnt_q + 1'b1;
    end
  end

  // R3: the output only returns high on a strobe
  assert_end_on_stb_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active_q) |-> $past(stb));

  // R5: a held pulse leaves as soon as the output is free
  assert_pend_issue_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_q && pend_q && !block) |=> active_q);

  // R8: no pulse begins while gated
  assert_no_start_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active_q) |-> $past(!block));
endmodule

// File: rtl/energy_pulse_gen.sv
module energy_pulse_gen
  import epg_pkg::*;
#(
  parameter int WIDTH_W   = 24,
  parameter int DEF_WIDTH = 512
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sample_stb,
  input  logic signed [DATA_W-1:0] power_in,
  input  logic [DATA_W-1:0]        quantum,
  input  logic                     no_load,
  input  logic                     wr_en,
  input  logic                     wr_addr,
  input  logic [WIDTH_W-1:0]       wr_data,
  output logic                     pulse_a_n,
  output logic                     pulse_b_n
);
  localparam int NCH = 2;

  logic [WIDTH_W-1:0] width_q;
  logic [CTRL_W-1:0]  ctrl_q;
  logic               gate;
  fmt_e               fmt;
  logic               ev_fwd;
  logic               ev_rev;
  logic [NCH-1:0]     req;
  logic [NCH-1:0]     out_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      width_q <= WIDTH_W'(DEF_WIDTH);
      ctrl_q  <= '0;
    end else if (wr_en) begin
      if (wr_addr) ctrl_q  <= wr_data[CTRL_W-1:0];
      else         width_q <= wr_data;
    end
  end

  assign gate = ctrl_q[2] && no_load;
  assign fmt  = decode_fmt(ctrl_q);

  epg_accum u_accum (
    .clk(clk), .rst_n(rst_n), .stb(sample_stb), .block(gate),
    .sample(power_in), .quantum(quantum), .ev_fwd(ev_fwd), .ev_rev(ev_rev)
  );

  epg_route u_route (
    .clk(clk), .rst_n(rst_n), .fmt(fmt), .ev_fwd(ev_fwd), .ev_rev(ev_rev),
    .req_a(req[0]), .req_b(req[1])
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    epg_channel #(.WIDTH_W(WIDTH_W)) u_ch (
      .clk(clk), .rst_n(rst_n), .stb(sample_stb), .block(gate),
      .req(req[i]), .width(width_q), .pulse_n(out_n[i])
    );
  end

  assign pulse_a_n = out_n[0];
  assign pulse_b_n = out_n[1];

  // R9: with anti-creep off, no_load never gates anything
  assert_nogate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[2] |-> !gate);

  // R1: outputs idle high straight out of reset
  assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pulse_a_n && pulse_b_n));
endmodule

// File: tb/energy_pulse_gen_bench.sv
module energy_pulse_gen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  // {sample, expected A pulses, expected B pulses}, quantum 100, normal format
  localparam logic [31:0] VEC [NVEC] = '{
    {16'd60,   8'd0, 8'd0},
    {16'd60,   8'd1, 8'd0},
    {16'hFFCE, 8'd0, 8'd0},
    {16'hFFB0, 8'd0, 8'd1},
    {16'd99,   8'd0, 8'd0},
    {16'd11,   8'd1, 8'd0},
    {16'hFF9C, 8'd0, 8'd1},
    {16'd0,    8'd0, 8'd0}
  };

  logic clk = 0, rst_n = 0, sample_stb = 0, no_load = 0, wr_en = 0, wr_addr = 0;
  logic signed [15:0] power_in = '0;
  logic [15:0] quantum = 16'd100;
  logic [23:0] wr_data = '0;
  logic pulse_a_n, pulse_b_n;
  int checks = 0, fails = 0, falls_a = 0, falls_b = 0, low_a = 0;
  logic prev_a = 1, prev_b = 1, done = 0;

  energy_pulse_gen u_energy_pulse_gen (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (prev_a && !pulse_a_n) falls_a++;
    if (prev_b && !pulse_b_n) falls_b++;
    if (!pulse_a_n) low_a++;
    prev_a = pulse_a_n;
    prev_b = pulse_b_n;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic strobe(input int p);
    @(negedge clk); power_in = 16'(p); sample_stb = 1;
    @(negedge clk); sample_stb = 0; power_in = '0;
    repeat (2) @(negedge clk);
  endtask

  task automatic wr(input bit a, input int d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = 24'(d);
    @(negedge clk); wr_en = 0;
  endtask

  // one sample followed by two empty strobes, then compare pulse counts
  task automatic quantum_step(input int p, input int ea, input int eb, input string req);
    int a0, b0;
    a0 = falls_a; b0 = falls_b;
    strobe(p); strobe(0); strobe(0);
    check(falls_a - a0 == ea, req, falls_a - a0, ea);
    check(falls_b - b0 == eb, req, falls_b - b0, eb);
  endtask

  task automatic measure_width(input int w, input int exp_clk, input string req);
    if (w >= 0) wr(0, w);
    @(negedge clk); low_a = 0;
    strobe(100);
    repeat ((w > 0 ? w : 1) + 2) strobe(0);
    check(low_a == exp_clk, req, low_a, exp_clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int a0, b0;
    repeat (3) @(negedge clk);
    check(pulse_a_n && pulse_b_n, "R1 idle during reset", pulse_a_n, 1);
    rst_n = 1;
    @(negedge clk);
    check(pulse_a_n && pulse_b_n, "R1 idle after reset", pulse_b_n, 1);

    // R1: default width 512 strobes at 4 clocks each
    @(negedge clk); low_a = 0;
    strobe(100);
    repeat (514) strobe(0);
    check(low_a == 2048, "R1 default width", low_a, 2048);

    // R2: table walk in normal format with width 1 (R4 write)
    wr(0, 1);
    for (int i = 0; i < NVEC; i++)
      quantum_step(int'($signed(VEC[i][31:16])), int'(VEC[i][15:8]), int'(VEC[i][7:0]), "R2 vector");

    measure_width(3, 12, "R3 R4 width 3");
    measure_width(0, 4, "R3 width zero");

    // R5: second quantum while low is queued
    wr(0, 2);
    a0 = falls_a;
    strobe(100); strobe(100); repeat (4) strobe(0);
    check(falls_a - a0 == 2, "R5 pending issued", falls_a - a0, 2);
    // R5: third quantum while one is already pending is dropped
    wr(0, 3);
    a0 = falls_a;
    strobe(100); strobe(100); strobe(100); repeat (6) strobe(0);
    check(falls_a - a0 == 2, "R5 overflow dropped", falls_a - a0, 2);

    // R6: mechanical-counter format
    wr(0, 1);
    wr(1, 2);
    quantum_step(100, 1, 0, "R6 forward on A");
    quantum_step(-100, 0, 0, "R6 reverse silent");

    // R7: stepper format alternates A, B
    wr(1, 1);
    for (int i = 0; i < 4; i++)
      quantum_step(100, (i % 2 == 0) ? 1 : 0, (i % 2 == 1) ? 1 : 0, "R7 alternate");
    quantum_step(-100, 0, 0, "R7 reverse silent");
    wr(1, 3);
    quantum_step(100, 1, 0, "R7 precedence");
    quantum_step(100, 0, 1, "R7 precedence second");

    // R8: anti-creep gates accumulation and pulse start
    wr(1, 4);
    no_load = 1;
    quantum_step(100, 0, 0, "R8 gated no pulse");
    no_load = 0;
    quantum_step(0, 0, 0, "R8 energy not kept");
    quantum_step(100, 1, 0, "R8 ungated pulse");

    // R9: no_load ignored with anti-creep off
    wr(1, 0);
    no_load = 1;
    quantum_step(100, 1, 0, "R9 forward");
    quantum_step(-100, 0, 1, "R9 reverse");
    no_load = 0;

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule